// File: doc/BRIEF.md
# Redundant Bus Clock Role Controller with Host Watchdog

This block sits on each board of a multi-chassis system that shares one timing bus carrying two clock lines, called left and right. Host software assigns the board one of three clock roles. A primary master locks to the system 8 kHz reference and drives one of the two lines. A secondary master drives the other line from its own oscillator as a standby. A slave drives neither line and follows the line the primary drives. The block decides which line the board drives and which source it references. It watches that source for lost activity and reacts according to the board's role.

Loss is declared when the watched source shows no transition for a programmable number of local cycles. On a loss, a slave with fallback enabled moves its reference to the standby line. A secondary master instead drops its bus reference and runs from its own oscillator. A primary master only flags the error. The error, fallback and reversion states stay latched until the host writes a new configuration.

A host watchdog, when enabled, must be kept alive by status reads. If no status read arrives before it expires, the board stops driving data and both clock lines, and stays isolated until the next configuration write. Three indicator outputs give a fixed status code: error, driving a clock line, and right line in use.

Top module: `clk_redund_ctrl`

## Requirements
- R1: Configuration is captured on a cycle with `cfg_wr` high. Role codes on `cfg_role` are 00 slave, 01 primary master, 10 secondary master and 11 slave. With `cfg_pri_right`=1 the primary's line is right, and with 0 it is left. A primary drives its line, a secondary drives the opposite line and a slave drives neither. The two line enables are never high together.
- R2: `ref_sel` encodes the reference in use as 0 for the 8 kHz reference, 1 for the left line, 2 for the right line and 3 for the internal oscillator. A primary references 0. A secondary and a slave reference the primary's line until a loss changes it.
- R3: The watched source is the one named by `ref_sel`. If it shows no level change for `cfg_limit` consecutive cycles after the configuration write or after its last change, `clk_err` rises exactly at the `cfg_limit`-th such cycle. A limit of 0 disables loss detection.
- R4: On a loss, a slave with fallback enabled switches `ref_sel` to the opposite line and restarts monitoring on that line. With fallback disabled the reference does not move.
- R5: On a loss, a secondary master switches `ref_sel` to 3 and keeps driving its line. The fallback enable has no effect on non-slave roles.
- R6: On loss of the 8 kHz reference, a primary master sets `clk_err`, keeps driving its line and keeps `ref_sel` at 0.
- R7: `clk_err`, slave fallback and secondary reversion stay latched until the next `cfg_wr`. A `cfg_wr` clears them.
- R8: With the watchdog enabled, `WDOG_CYCLES` consecutive cycles without `stat_rd` after the configuration write or the last read force `data_drv_en`, `drv_left_en` and `drv_right_en` low. A disabled watchdog never isolates the board.
- R9: Once the watchdog has expired, isolation persists, and `stat_rd` does not end it. Only `cfg_wr` ends it.
- R10: `led_red` equals `clk_err`. `led_yellow` is high while a line enable is high. `led_green` is high when the line in use is right: the driven line for a master and the referenced line for a slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_role | input | 2 | Clock role code |
| cfg_pri_right | input | 1 | Primary master's line is right (1) or left (0) |
| cfg_fb_en | input | 1 | Slave automatic fallback enable |
| cfg_wd_en | input | 1 | Host watchdog enable |
| cfg_limit | input | LOSS_W | Loss timeout in local cycles, 0 disables |
| ref8k_act | input | 1 | Synchronized level of the 8 kHz reference |
| left_act | input | 1 | Synchronized level of the left bus clock line |
| right_act | input | 1 | Synchronized level of the right bus clock line |
| stat_rd | input | 1 | Host status read strobe, refreshes the watchdog |
| drv_left_en | output | 1 | Drive enable for the left clock line |
| drv_right_en | output | 1 | Drive enable for the right clock line |
| data_drv_en | output | 1 | Bus data drive enable |
| ref_sel | output | 2 | Reference source in use |
| clk_err | output | 1 | Latched clock loss error |
| led_red | output | 1 | Error indicator |
| led_yellow | output | 1 | Clock-driving indicator |
| led_green | output | 1 | Right-line-in-use indicator |

## Verification
The bench probes the loss timeout one cycle short of the limit and at the limit. An off-by-one counter would raise the error a cycle early or a cycle late. It drives a slave whose primary line dies, then lets the backup stay alive or also die. A design that monitored the wrong line, or that cleared its fallback on a later edge, would show the wrong reference or drop the error. The watchdog is tested against its exact expiry after a mid-window status read, and status reads are sent while the board is isolated. A design that restarted the count badly, or that let a read lift the isolation, would drive the bus when it must not. A zero limit, a secondary reverting with fallback enabled, and randomized role and line-death mixes catch role decoding that confuses the slave-only and secondary-only reactions.

// File: rtl/clk_redund_pkg.sv
package clk_redund_pkg;

    typedef enum logic [1:0] {
        ROLE_SLAVE     = 2'b00,
        ROLE_PRIMARY   = 2'b01,
        ROLE_SECONDARY = 2'b10,
        ROLE_SLAVE_ALT = 2'b11
    } role_e;

    typedef enum logic [1:0] {
        SRC_REF8K = 2'd0,
        SRC_LEFT  = 2'd1,
        SRC_RIGHT = 2'd2,
        SRC_OSC   = 2'd3
    } src_e;

    localparam int N_WATCH = 3;

endpackage

// File: rtl/clk_loss_mon.sv
module clk_loss_mon #(
    parameter int LOSS_W = 16,
    parameter int N_SRC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic [LOSS_W-1:0] limit,
    input  logic [1:0]        sel,
    input  logic [N_SRC-1:0]  act,
    output logic              loss
);

    typedef struct packed {
        logic [N_SRC-1:0]  prev;
        logic [LOSS_W-1:0] cnt;
    } mon_t;

    mon_t             st_d, st_q;
    logic [N_SRC-1:0] edge_v;
    logic             sel_edge;

    // one transition detector per watchable source
    for (genvar g = 0; g < N_SRC; g++) begin : g_edge
        assign edge_v[g] = act[g] ^ st_q.prev[g];
    end

    always_comb begin
        sel_edge = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == 2'(i)) sel_edge = edge_v[i];
        end
    end

    assign loss = enable && (limit != '0) && !sel_edge
                  && (st_q.cnt == (limit - LOSS_W'(1)));

    always_comb begin
        st_d      = st_q;
        st_d.prev = act;
        if (clear || !enable || sel_edge) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != limit) begin
            st_d.cnt = st_q.cnt + LOSS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/host_wdog.sv
module host_wdog #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic kick,
    input  logic rearm,
    output logic fired
);

    localparam int W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         fired;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        if (rearm) begin
            wd_d.cnt   = '0;
            wd_d.fired = 1'b0;
        end else if (wd_q.fired) begin
            wd_d = wd_q;
        end else if (!en || kick) begin
            wd_d.cnt = '0;
        end else if (wd_q.cnt == W'(CYCLES - 1)) begin
            wd_d.fired = 1'b1;
        end else begin
            wd_d.cnt = wd_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign fired = wd_q.fired;

endmodule

// File: rtl/clk_redund_ctrl.sv
module clk_redund_ctrl
    import clk_redund_pkg::*;
#(
    parameter int LOSS_W      = 16,
    parameter int WDOG_CYCLES = 1000,
    parameter int RST_LIMIT   = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_role,
    input  logic              cfg_pri_right,
    input  logic              cfg_fb_en,
    input  logic              cfg_wd_en,
    input  logic [LOSS_W-1:0] cfg_limit,
    input  logic              ref8k_act,
    input  logic              left_act,
    input  logic              right_act,
    input  logic              stat_rd,
    output logic              drv_left_en,
    output logic              drv_right_en,
    output logic              data_drv_en,
    output logic [1:0]        ref_sel,
    output logic              clk_err,
    output logic              led_red,
    output logic              led_yellow,
    output logic              led_green
);

    typedef struct packed {
        role_e             role;
        logic              pri_right;
        logic              fb_en;
        logic              wd_en;
        logic [LOSS_W-1:0] limit;
        logic              err;
        logic              fb;
        logic              rev;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        role:      ROLE_SLAVE,
        pri_right: 1'b0,
        fb_en:     1'b0,
        wd_en:     1'b0,
        limit:     LOSS_W'(RST_LIMIT),
        err:       1'b0,
        fb:        1'b0,
        rev:       1'b0
    };

    ctl_t  ctl_d, ctl_q;
    logic  is_slave, is_pri, is_sec;
    src_e  pri_src, bak_src, ref_src;
    logic  loss, mon_clear, mon_en, fired;
    logic  drv_l_raw, drv_r_raw;

    assign is_pri   = (ctl_q.role == ROLE_PRIMARY);
    assign is_sec   = (ctl_q.role == ROLE_SECONDARY);
    assign is_slave = !is_pri && !is_sec;
    assign pri_src  = ctl_q.pri_right ? SRC_RIGHT : SRC_LEFT;
    assign bak_src  = ctl_q.pri_right ? SRC_LEFT  : SRC_RIGHT;

    always_comb begin
        if (is_pri)      ref_src = SRC_REF8K;
        else if (is_sec) ref_src = ctl_q.rev ? SRC_OSC : pri_src;
        else             ref_src = ctl_q.fb  ? bak_src : pri_src;
    end

    assign mon_en    = (ref_src != SRC_OSC);
    assign mon_clear = cfg_wr || (loss && is_slave && ctl_q.fb_en && !ctl_q.fb);

    clk_loss_mon #(
        .LOSS_W (LOSS_W),
        .N_SRC  (N_WATCH)
    ) u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (mon_clear),
        .enable (mon_en),
        .limit  (ctl_q.limit),
        .sel    (ref_src),
        .act    ({right_act, left_act, ref8k_act}),
        .loss   (loss)
    );

    host_wdog #(
        .CYCLES (WDOG_CYCLES)
    ) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctl_q.wd_en),
        .kick   (stat_rd),
        .rearm  (cfg_wr),
        .fired  (fired)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (cfg_wr) begin
            ctl_d.role      = role_e'(cfg_role);
            ctl_d.pri_right = cfg_pri_right;
            ctl_d.fb_en     = cfg_fb_en;
            ctl_d.wd_en     = cfg_wd_en;
            ctl_d.limit     = cfg_limit;
            ctl_d.err       = 1'b0;
            ctl_d.fb        = 1'b0;
            ctl_d.rev       = 1'b0;
        end else if (loss) begin
            ctl_d.err = 1'b1;
            if (is_sec) begin
                ctl_d.rev = 1'b1;
            end else if (is_slave && ctl_q.fb_en) begin
                ctl_d.fb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign drv_l_raw = (is_pri && !ctl_q.pri_right) || (is_sec && ctl_q.pri_right);
    assign drv_r_raw = (is_pri &&  ctl_q.pri_right) || (is_sec && !ctl_q.pri_right);

    assign drv_left_en  = drv_l_raw && !fired;
    assign drv_right_en = drv_r_raw && !fired;
    assign data_drv_en  = !fired;
    assign ref_sel      = ref_src;
    assign clk_err      = ctl_q.err;

    assign led_red    = ctl_q.err;
    assign led_yellow = drv_left_en || drv_right_en;

    always_comb begin
        if (is_pri)      led_green = ctl_q.pri_right;
        else if (is_sec) led_green = !ctl_q.pri_right;
        else             led_green = (ref_src == SRC_RIGHT);
    end

endmodule

// File: rtl/clk_redund_ctrl_chk.sv
module clk_redund_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic       drv_left_en,
    input logic       drv_right_en,
    input logic       data_drv_en,
    input logic [1:0] ref_sel,
    input logic       clk_err,
    input logic       led_red,
    input logic       led_yellow
);

    p_one_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_left_en && drv_right_en));

    p_isolate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !data_drv_en |-> (!drv_left_en && !drv_right_en));

    p_err_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_err && !cfg_wr) |=> clk_err);

    p_iso_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_drv_en && !cfg_wr) |=> !data_drv_en);

    p_err_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_err) |-> !$past(cfg_wr));

    p_osc_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_sel == 2'd3) |-> (clk_err && (led_yellow || !data_drv_en)));

    p_red_r10: assert property (@(posedge clk) disable iff (!rst_n)
        led_red == clk_err);

    p_yellow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        led_yellow == (drv_left_en || drv_right_en));

endmodule

bind clk_redund_ctrl clk_redund_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .drv_left_en  (drv_left_en),
    .drv_right_en (drv_right_en),
    .data_drv_en  (data_drv_en),
    .ref_sel      (ref_sel),
    .clk_err      (clk_err),
    .led_red      (led_red),
    .led_yellow   (led_yellow)
);

// File: tb/clk_redund_ctrl_tb.sv
module clk_redund_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 16;
    localparam int WD = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_role = 2'b00;
    logic          cfg_pri_right = 1'b0;
    logic          cfg_fb_en = 1'b0;
    logic          cfg_wd_en = 1'b0;
    logic [LW-1:0] cfg_limit = '0;
    logic          ref8k_act = 1'b0;
    logic          left_act = 1'b0;
    logic          right_act = 1'b0;
    logic          stat_rd = 1'b0;
    logic          drv_left_en, drv_right_en, data_drv_en;
    logic [1:0]    ref_sel;
    logic          clk_err, led_red, led_yellow, led_green;

    logic alive_ref = 1'b0, alive_l = 1'b0, alive_r = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_redund_ctrl #(
        .LOSS_W      (LW),
        .WDOG_CYCLES (WD),
        .RST_LIMIT   (255)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_role (cfg_role),
        .cfg_pri_right (cfg_pri_right), .cfg_fb_en (cfg_fb_en),
        .cfg_wd_en (cfg_wd_en), .cfg_limit (cfg_limit),
        .ref8k_act (ref8k_act), .left_act (left_act), .right_act (right_act),
        .stat_rd (stat_rd), .drv_left_en (drv_left_en),
        .drv_right_en (drv_right_en), .data_drv_en (data_drv_en),
        .ref_sel (ref_sel), .clk_err (clk_err), .led_red (led_red),
        .led_yellow (led_yellow), .led_green (led_green)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock; inputs change 1 time unit after the edge, outputs read then
    task automatic tick();
        @(posedge clk);
        #1;
        if (alive_ref) ref8k_act = ~ref8k_act;
        if (alive_l)   left_act  = ~left_act;
        if (alive_r)   right_act = ~right_act;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic configure(input logic [1:0] role, input logic pr,
                             input logic fb, input logic wd, input int lim);
        cfg_role = role; cfg_pri_right = pr; cfg_fb_en = fb;
        cfg_wd_en = wd; cfg_limit = LW'(lim); cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
    endtask

    // expected steady state after all losses have played out
    task automatic chk_steady(input string tag, input logic [1:0] role,
                              input logic pr, input logic fb);
        logic pa, ba, e_err, e_dl, e_dr, e_gr;
        int   e_ref;
        pa = pr ? alive_r : alive_l;
        ba = pr ? alive_l : alive_r;
        if (role == 2'b01) begin
            e_err = !alive_ref; e_ref = 0; e_dl = !pr; e_dr = pr; e_gr = pr;
        end else if (role == 2'b10) begin
            e_err = !pa; e_ref = pa ? (pr ? 2 : 1) : 3;
            e_dl = pr; e_dr = !pr; e_gr = !pr;
        end else begin
            e_dl = 1'b0; e_dr = 1'b0;
            if (pa) begin
                e_err = 1'b0; e_ref = pr ? 2 : 1;
            end else begin
                e_err = 1'b1;
                e_ref = (fb ? !pr : pr) ? 2 : 1;
            end
            e_gr = (e_ref == 2);
            if (ba) e_gr = e_gr;
        end
        chk({tag, " R1 drv_left"},  drv_left_en,  e_dl);
        chk({tag, " R1 drv_right"}, drv_right_en, e_dr);
        chk({tag, " R2/R4/R5 ref"}, ref_sel,      e_ref);
        chk({tag, " R3/R6 err"},    clk_err,      e_err);
        chk({tag, " R10 red"},      led_red,      e_err);
        chk({tag, " R10 yellow"},   led_yellow,   e_dl | e_dr);
        chk({tag, " R10 green"},    led_green,    e_gr);
    endtask

    initial begin : watchdog_timer
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd4711));
        #(3*CLK_PERIOD + 1);
        rst_n = 1'b1;
        #1;
        // reset state
        chk("R1 reset drv_left",  drv_left_en, 0);
        chk("R1 reset drv_right", drv_right_en, 0);
        chk("R8 reset data_drv",  data_drv_en, 1);
        chk("R2 reset ref",       ref_sel, 1);
        chk("R10 reset red",      led_red, 0);
        chk("R10 reset green",    led_green, 0);

        // R3 exact timeout boundary, slave without fallback (R4 disabled)
        alive_l = 0; alive_r = 1; alive_ref = 1;
        configure(2'b00, 1'b0, 1'b0, 1'b0, 5);
        ticks(4);
        chk("R3 no err at limit-1", clk_err, 0);
        tick();
        chk("R3 err at limit", clk_err, 1);
        chk("R4 no fallback when disabled", ref_sel, 1);
        chk("R10 red on error", led_red, 1);

        // R4 fallback to backup line, R7 latch
        configure(2'b00, 1'b0, 1'b1, 1'b0, 5);
        ticks(4);
        chk("R4 ref before loss", ref_sel, 1);
        tick();
        chk("R4 fallback ref", ref_sel, 2);
        chk("R10 green on right", led_green, 1);
        alive_l = 1;
        ticks(12);
        chk("R7 err latched", clk_err, 1);
        chk("R7 fallback latched", ref_sel, 2);
        configure(2'b00, 1'b0, 1'b1, 1'b0, 5);
        chk("R7 cfg clears err", clk_err, 0);
        chk("R7 cfg clears fallback", ref_sel, 1);

        // R4 backup also dead: fallback then stays with error
        alive_l = 0; alive_r = 0;
        configure(2'b11, 1'b1, 1'b1, 1'b0, 4);
        ticks(20);
        chk("R4 both dead ref", ref_sel, 1);
        chk("R4 both dead err", clk_err, 1);

        // R3 limit zero disables detection
        alive_ref = 0;
        configure(2'b00, 1'b0, 1'b1, 1'b0, 0);
        ticks(30);
        chk("R3 limit 0 err", clk_err, 0);
        chk("R3 limit 0 ref", ref_sel, 1);

        // R5 secondary reverts to oscillator even with fallback enabled
        alive_l = 0; alive_r = 1; alive_ref = 1;
        configure(2'b10, 1'b0, 1'b1, 1'b0, 4);
        ticks(3);
        chk("R5 secondary ref before loss", ref_sel, 1);
        tick();
        chk("R5 secondary osc", ref_sel, 3);
        chk("R5 secondary keeps driving", drv_right_en, 1);
        chk("R10 secondary yellow", led_yellow, 1);
        chk("R10 secondary green", led_green, 1);

        // R6 primary loses 8 kHz reference
        alive_ref = 0; alive_l = 1; alive_r = 1;
        configure(2'b01, 1'b1, 1'b1, 1'b0, 4);
        ticks(4);
        chk("R6 primary err", clk_err, 1);
        chk("R6 primary drives right", drv_right_en, 1);
        chk("R6 primary ref", ref_sel, 0);

        // R8 / R9 watchdog
        alive_ref = 1; alive_l = 1; alive_r = 1;
        configure(2'b01, 1'b0, 1'b0, 1'b1, 10);
        ticks(20);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        ticks(WD - 1);
        chk("R8 alive at WD-1 after read", data_drv_en, 1);
        chk("R8 driving at WD-1", drv_left_en, 1);
        tick();
        chk("R8 isolated data", data_drv_en, 0);
        chk("R8 isolated left", drv_left_en, 0);
        chk("R10 yellow off isolated", led_yellow, 0);
        for (int i = 0; i < 5; i++) begin
            stat_rd = 1'b1; tick();
        end
        stat_rd = 1'b0;
        chk("R9 read does not end isolation", data_drv_en, 0);
        configure(2'b01, 1'b0, 1'b0, 1'b0, 10);
        chk("R9 cfg ends isolation", data_drv_en, 1);
        ticks(WD + 20);
        chk("R8 disabled never fires", data_drv_en, 1);

        // randomized roles and line deaths (R1 R2 R3 R4 R5 R6 R10)
        for (int t = 0; t < 60; t++) begin
            logic [1:0] role;
            logic pr, fb;
            int   lim;
            role = 2'($urandom_range(0, 3));
            pr = 1'($urandom_range(0, 1));
            fb = 1'($urandom_range(0, 1));
            lim = $urandom_range(3, 12);
            alive_ref = 1'($urandom_range(0, 1));
            alive_l = 1'($urandom_range(0, 1));
            alive_r = 1'($urandom_range(0, 1));
            configure(role, pr, fb, 1'b0, lim);
            for (int k = 0; k < 3*lim + 5; k++) begin
                stat_rd = 1'($urandom_range(0, 1));
                tick();
            end
            stat_rd = 1'b0;
            chk_steady($sformatf("rand%0d", t), role, pr, fb);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule